// File: doc/BRIEF.md
# Operand-Latched ALU with Split Result Drivers

This block is the arithmetic and logic unit of a small 8-bit processor datapath. A decoder drives it with individual control strobes. Two operand registers, called A and B, capture values from the internal buses. A then holds either zero or the SB bus. B holds the DB bus, the bitwise complement of the DB bus, or the ADL bus. Subtraction is done by loading the complement into B and asserting carry-in.

On the next edge, one of five operation strobes computes a result from the latched operands. The five operations are add with carry, AND, exclusive-OR, OR, and logical shift right of A. The result goes into a hold register, together with a carry flag (ACR) and a signed-overflow flag (AVR) for the status logic. The hold register keeps its value until another operation strobe arrives.

The hold register can be presented on the ADL bus as a whole. It can also be presented on the SB bus, where bits 0-6 and bit 7 have separate enables. Each bus output is modelled as a data value plus valid flags, and undriven bits read as zero. Only binary arithmetic is supported; no decimal correction is applied.

Top module: `opalu_top`

## Requirements
- R1: While reset is applied, and after it is released, the operand registers, the hold register and both flags are zero.
- R2: A clock edge with `ld_a_sb` high loads `sb_bus` into operand A, and an edge with `ld_a_zero` high loads zero. When neither is high, A keeps its value.
- R3: An edge with `ld_b_db` loads `db_bus` into operand B. An edge with `ld_b_dbinv` loads the bitwise complement of `db_bus`, and an edge with `ld_b_adl` loads `adl_bus`.
- R4: An edge with `op_sum` stores (A + B + `carry_in`) mod 256. The same edge sets `carry_out` to the ninth bit of that sum and sets `ovf_out` when A and B have the same sign but the result's bit 7 differs from it.
- R5: An edge with `op_and`, `op_xor` or `op_or` stores A AND B, A XOR B or A OR B respectively, and clears both flags.
- R6: An edge with `op_shr` stores A shifted right by one with a zero entering bit 7. It sets `carry_out` to A bit 0 and clears `ovf_out`.
- R7: On an edge with no operation strobe, the hold register and both flags keep their values, even if the buses and operands change.
- R8: While `drv_adl` is high, `adl_out` shows the hold register and `adl_out_vld` is high. Otherwise both are zero.
- R9: `sb_out` bits 0-6 show the hold register while `drv_sb_lo` is high, and bit 7 shows it while `drv_sb_hi` is high. Undriven bits are zero, and `sb_lo_vld`/`sb_hi_vld` follow their enables.
- R10: An operation uses the operand values latched before its edge. An operand load on that same edge affects only the next operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_bus | input | 8 | SB bus value |
| db_bus | input | 8 | DB bus value |
| adl_bus | input | 8 | ADL bus value |
| ld_a_zero | input | 1 | Load zero into A |
| ld_a_sb | input | 1 | Load SB bus into A |
| ld_b_db | input | 1 | Load DB bus into B |
| ld_b_dbinv | input | 1 | Load complemented DB bus into B |
| ld_b_adl | input | 1 | Load ADL bus into B |
| carry_in | input | 1 | Carry input of the adder |
| op_sum | input | 1 | Add with carry |
| op_and | input | 1 | Bitwise AND |
| op_xor | input | 1 | Bitwise exclusive-OR |
| op_or | input | 1 | Bitwise OR |
| op_shr | input | 1 | Logical shift right of A |
| drv_adl | input | 1 | Present hold register on ADL output |
| drv_sb_lo | input | 1 | Present hold bits 0-6 on SB output |
| drv_sb_hi | input | 1 | Present hold bit 7 on SB output |
| adl_out | output | 8 | ADL bus data from hold register |
| adl_out_vld | output | 1 | ADL output driven |
| sb_out | output | 8 | SB bus data from hold register |
| sb_lo_vld | output | 1 | SB bits 0-6 driven |
| sb_hi_vld | output | 1 | SB bit 7 driven |
| carry_out | output | 1 | ACR flag |
| ovf_out | output | 1 | AVR flag |

## Verification
The hardest case to reach from the ports is an operand load on the same edge as an operation. Here the result must come from the operands latched earlier, not from the value arriving on the bus. The bench sets up known operands and then asserts an add together with a new A load in one cycle. It checks that the first result ignores the new value and that the following add uses it. Signed overflow from a subtraction is also hard to reach, because it needs the complemented B path and carry-in together. The vector table covers it with 0x80 minus 1.

// File: rtl/opalu_pkg.sv
package opalu_pkg;

  typedef enum logic [2:0] {
    FN_NONE = 3'd0,
    FN_SUM  = 3'd1,
    FN_AND  = 3'd2,
    FN_XOR  = 3'd3,
    FN_OR   = 3'd4,
    FN_SHR  = 3'd5
  } fn_e;

  typedef struct packed {
    logic acr;
    logic avr;
  } flags_t;

  function automatic fn_e fn_decode(input logic s, input logic a,
                                    input logic x, input logic o,
                                    input logic r);
    fn_e f;
    if (s)      f = FN_SUM;
    else if (a) f = FN_AND;
    else if (x) f = FN_XOR;
    else if (o) f = FN_OR;
    else if (r) f = FN_SHR;
    else        f = FN_NONE;
    return f;
  endfunction

endpackage

// File: rtl/opalu_rst_sync.sv
module opalu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/opalu_operands.sv
module opalu_operands #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sb_bus,
  input  logic [W-1:0] db_bus,
  input  logic [W-1:0] adl_bus,
  input  logic         ld_a_zero,
  input  logic         ld_a_sb,
  input  logic         ld_b_db,
  input  logic         ld_b_dbinv,
  input  logic         ld_b_adl,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);

  logic         a_en, b_en;
  logic [W-1:0] a_d, b_d;

  always_comb begin
    a_en = ld_a_zero | ld_a_sb;
    a_d  = ld_a_zero ? '0 : sb_bus;
  end

  always_comb begin
    b_en = ld_b_db | ld_b_dbinv | ld_b_adl;
    if (ld_b_db)         b_d = db_bus;
    else if (ld_b_dbinv) b_d = ~db_bus;
    else                 b_d = adl_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a_q <= '0;
    else if (a_en) a_q <= a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    b_q <= '0;
    else if (b_en) b_q <= b_d;
  end

endmodule

// File: rtl/opalu_func.sv
module opalu_func
  import opalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  fn_e          fn,
  output logic [W-1:0] res,
  output flags_t       flg
);

  localparam int MSB = W - 1;

  logic [W:0] sum_ext;

  always_comb begin
    sum_ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    res     = '0;
    flg     = '0;
    case (fn)
      FN_SUM: begin
        res     = sum_ext[W-1:0];
        flg.acr = sum_ext[W];
        flg.avr = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
      end
      FN_AND: res = a & b;
      FN_XOR: res = a ^ b;
      FN_OR:  res = a | b;
      FN_SHR: begin
        res     = {1'b0, a[W-1:1]};
        flg.acr = a[0];
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/opalu_hold.sv
module opalu_hold
  import opalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] res_d,
  input  flags_t       flg_d,
  input  logic         drv_adl,
  input  logic         drv_sb_lo,
  input  logic         drv_sb_hi,
  output logic [W-1:0] hold_q,
  output flags_t       flg_q,
  output logic [W-1:0] adl_out,
  output logic         adl_out_vld,
  output logic [W-1:0] sb_out,
  output logic         sb_lo_vld,
  output logic         sb_hi_vld
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      flg_q  <= '0;
    end else if (upd) begin
      hold_q <= res_d;
      flg_q  <= flg_d;
    end
  end

  assign adl_out     = drv_adl ? hold_q : '0;
  assign adl_out_vld = drv_adl;
  assign sb_lo_vld   = drv_sb_lo;
  assign sb_hi_vld   = drv_sb_hi;

  for (genvar i = 0; i < W - 1; i++) begin : g_sb_lo
    assign sb_out[i] = drv_sb_lo & hold_q[i];
  end
  assign sb_out[W-1] = drv_sb_hi & hold_q[W-1];

endmodule

// File: rtl/opalu_top.sv
module opalu_top
  import opalu_pkg::*;
#(
  parameter int W          = 8,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sb_bus,
  input  logic [W-1:0] db_bus,
  input  logic [W-1:0] adl_bus,
  input  logic         ld_a_zero,
  input  logic         ld_a_sb,
  input  logic         ld_b_db,
  input  logic         ld_b_dbinv,
  input  logic         ld_b_adl,
  input  logic         carry_in,
  input  logic         op_sum,
  input  logic         op_and,
  input  logic         op_xor,
  input  logic         op_or,
  input  logic         op_shr,
  input  logic         drv_adl,
  input  logic         drv_sb_lo,
  input  logic         drv_sb_hi,
  output logic [W-1:0] adl_out,
  output logic         adl_out_vld,
  output logic [W-1:0] sb_out,
  output logic         sb_lo_vld,
  output logic         sb_hi_vld,
  output logic         carry_out,
  output logic         ovf_out
);

  logic         rst_sync_n;
  logic [W-1:0] a_q, b_q, res_d, hold_q;
  fn_e          fn;
  flags_t       flg_d, flg_q;

  opalu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  opalu_operands #(.W(W)) u_opnd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sb_bus     (sb_bus),
    .db_bus     (db_bus),
    .adl_bus    (adl_bus),
    .ld_a_zero  (ld_a_zero),
    .ld_a_sb    (ld_a_sb),
    .ld_b_db    (ld_b_db),
    .ld_b_dbinv (ld_b_dbinv),
    .ld_b_adl   (ld_b_adl),
    .a_q        (a_q),
    .b_q        (b_q)
  );

  assign fn = fn_decode(op_sum, op_and, op_xor, op_or, op_shr);

  opalu_func #(.W(W)) u_func (
    .a   (a_q),
    .b   (b_q),
    .cin (carry_in),
    .fn  (fn),
    .res (res_d),
    .flg (flg_d)
  );

  opalu_hold #(.W(W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .upd         (fn != FN_NONE),
    .res_d       (res_d),
    .flg_d       (flg_d),
    .drv_adl     (drv_adl),
    .drv_sb_lo   (drv_sb_lo),
    .drv_sb_hi   (drv_sb_hi),
    .hold_q      (hold_q),
    .flg_q       (flg_q),
    .adl_out     (adl_out),
    .adl_out_vld (adl_out_vld),
    .sb_out      (sb_out),
    .sb_lo_vld   (sb_lo_vld),
    .sb_hi_vld   (sb_hi_vld)
  );

  assign carry_out = flg_q.acr;
  assign ovf_out   = flg_q.avr;

endmodule

// File: rtl/opalu_chk.sv
module opalu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] db_bus,
  input logic [W-1:0] sb_out,
  input logic         carry_in,
  input logic         ld_a_zero,
  input logic         ld_b_dbinv,
  input logic         op_sum,
  input logic         op_and,
  input logic         op_xor,
  input logic         op_or,
  input logic         op_shr,
  input logic         drv_sb_hi,
  input logic         carry_out,
  input logic         ovf_out
);

  logic any_op;
  assign any_op = op_sum | op_and | op_xor | op_or | op_shr;

  // R2
  a_zero_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_a_zero |=> a_q == '0);

  // R3
  b_inv_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_b_dbinv |=> b_q == ~$past(db_bus));

  // R4
  sum_result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_sum |=> hold_q == W'($past(a_q) + $past(b_q) + W'($past(carry_in))));

  // R5
  and_result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_and |=> (hold_q == ($past(a_q) & $past(b_q))) && !carry_out && !ovf_out);

  // R6
  shr_result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_shr |=> !hold_q[W-1] && (carry_out == $past(a_q[0])) && !ovf_out);

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_op |=> $stable(hold_q) && $stable(carry_out) && $stable(ovf_out));

  // R9
  sb_hi_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !drv_sb_hi |-> !sb_out[W-1]);

endmodule

bind opalu_top opalu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .a_q        (a_q),
  .b_q        (b_q),
  .hold_q     (hold_q),
  .db_bus     (db_bus),
  .sb_out     (sb_out),
  .carry_in   (carry_in),
  .ld_a_zero  (ld_a_zero),
  .ld_b_dbinv (ld_b_dbinv),
  .op_sum     (op_sum),
  .op_and     (op_and),
  .op_xor     (op_xor),
  .op_or      (op_or),
  .op_shr     (op_shr),
  .drv_sb_hi  (drv_sb_hi),
  .carry_out  (carry_out),
  .ovf_out    (ovf_out)
);

// File: tb/opalu_top_tb.sv
module opalu_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 11;

  // vector: a[31:24] b[23:16] bmode[15:14] (0 db,1 ~db,2 adl) cin[13]
  //         op[12:10] (0 sum,1 and,2 xor,3 or,4 shr) res[9:2] acr[1] avr[0]
  localparam logic [31:0] VECS [NVEC] = '{
    {8'h50, 8'h50, 2'd0, 1'b0, 3'd0, 8'hA0, 1'b0, 1'b1},
    {8'hFF, 8'h01, 2'd0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
    {8'hFF, 8'h00, 2'd2, 1'b1, 3'd0, 8'h00, 1'b1, 1'b0},
    {8'h05, 8'h03, 2'd1, 1'b1, 3'd0, 8'h02, 1'b1, 1'b0},
    {8'h80, 8'h01, 2'd1, 1'b1, 3'd0, 8'h7F, 1'b1, 1'b1},
    {8'h7F, 8'h7F, 2'd2, 1'b1, 3'd0, 8'hFF, 1'b0, 1'b1},
    {8'hC3, 8'h5A, 2'd0, 1'b0, 3'd1, 8'h42, 1'b0, 1'b0},
    {8'hC3, 8'h5A, 2'd2, 1'b0, 3'd2, 8'h99, 1'b0, 1'b0},
    {8'hC3, 8'h5A, 2'd0, 1'b0, 3'd3, 8'hDB, 1'b0, 1'b0},
    {8'h81, 8'h00, 2'd0, 1'b0, 3'd4, 8'h40, 1'b1, 1'b0},
    {8'hFE, 8'h00, 2'd0, 1'b0, 3'd4, 8'h7F, 1'b0, 1'b0}
  };

  logic       clk, rst_n;
  logic [7:0] sb_bus, db_bus, adl_bus;
  logic       ld_a_zero, ld_a_sb, ld_b_db, ld_b_dbinv, ld_b_adl, carry_in;
  logic       op_sum, op_and, op_xor, op_or, op_shr;
  logic       drv_adl, drv_sb_lo, drv_sb_hi;
  logic [7:0] adl_out, sb_out;
  logic       adl_out_vld, sb_lo_vld, sb_hi_vld, carry_out, ovf_out;

  int n_checks = 0;
  int n_errors = 0;

  opalu_top u_dut (
    .clk(clk), .rst_n(rst_n), .sb_bus(sb_bus), .db_bus(db_bus), .adl_bus(adl_bus),
    .ld_a_zero(ld_a_zero), .ld_a_sb(ld_a_sb), .ld_b_db(ld_b_db),
    .ld_b_dbinv(ld_b_dbinv), .ld_b_adl(ld_b_adl), .carry_in(carry_in),
    .op_sum(op_sum), .op_and(op_and), .op_xor(op_xor), .op_or(op_or),
    .op_shr(op_shr), .drv_adl(drv_adl), .drv_sb_lo(drv_sb_lo),
    .drv_sb_hi(drv_sb_hi), .adl_out(adl_out), .adl_out_vld(adl_out_vld),
    .sb_out(sb_out), .sb_lo_vld(sb_lo_vld), .sb_hi_vld(sb_hi_vld),
    .carry_out(carry_out), .ovf_out(ovf_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_a_zero = 0; ld_a_sb = 0; ld_b_db = 0; ld_b_dbinv = 0; ld_b_adl = 0;
    carry_in = 0; op_sum = 0; op_and = 0; op_xor = 0; op_or = 0; op_shr = 0;
    drv_adl = 0; drv_sb_lo = 0; drv_sb_hi = 0;
  endtask

  task automatic load_ops(input logic [7:0] a, input logic [7:0] b, input logic [1:0] bm);
    @(negedge clk); idle();
    sb_bus = a; ld_a_sb = 1;
    case (bm)
      2'd0:    begin db_bus = b;  ld_b_db = 1;    end
      2'd1:    begin db_bus = b;  ld_b_dbinv = 1; end
      default: begin adl_bus = b; ld_b_adl = 1;   end
    endcase
  endtask

  task automatic run_op(input logic [2:0] op, input logic cin);
    @(negedge clk); idle();
    carry_in = cin;
    case (op)
      3'd0: op_sum = 1;
      3'd1: op_and = 1;
      3'd2: op_xor = 1;
      3'd3: op_or  = 1;
      default: op_shr = 1;
    endcase
  endtask

  task automatic show();
    @(negedge clk); idle();
    drv_adl = 1; drv_sb_lo = 1; drv_sb_hi = 1;
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    idle(); sb_bus = 0; db_bus = 0; adl_bus = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1; drv_adl = 1; #1;
    check("R1 adl during reset", adl_out, 8'h00);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    show();
    check("R1 hold after reset", adl_out, 8'h00);
    check("R1 flags after reset", {6'd0, carry_out, ovf_out}, 8'h00);
    // operands zero: OR of A and B gives zero
    run_op(3'd3, 1'b0); show();
    check("R1 operands after reset", adl_out, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VECS[i];
      load_ops(v[31:24], v[23:16], v[15:14]);
      run_op(v[12:10], v[13]);
      show();
      check($sformatf("R4/R5/R6/R3 vec%0d result", i), adl_out, v[9:2]);
      check($sformatf("R4/R5/R6 vec%0d flags", i), {6'd0, carry_out, ovf_out}, {6'd0, v[1], v[0]});
    end

    // R2: zero load overrides previous A; A holds without strobe
    load_ops(8'hAA, 8'h00, 2'd0);
    @(negedge clk); idle(); ld_a_zero = 1;
    run_op(3'd3, 1'b0); show();
    check("R2 zero load", adl_out, 8'h00);
    load_ops(8'h3C, 8'h00, 2'd0);
    @(negedge clk); idle(); sb_bus = 8'hFF;
    @(negedge clk); idle(); sb_bus = 8'h11;
    run_op(3'd3, 1'b0); show();
    check("R2 A holds", adl_out, 8'h3C);

    // R7: hold and flags kept with no op
    load_ops(8'hFF, 8'h02, 2'd0);
    run_op(3'd0, 1'b0);            // 0x01, acr=1
    load_ops(8'h12, 8'h34, 2'd2);
    @(negedge clk); idle(); db_bus = 8'h77; sb_bus = 8'h88;
    show();
    check("R7 hold kept", adl_out, 8'h01);
    check("R7 flags kept", {6'd0, carry_out, ovf_out}, 8'h02);

    // R8: ADL drive off
    @(negedge clk); idle(); #1;
    check("R8 adl undriven", {adl_out_vld, adl_out[6:0]}, 8'h00);
    check("R8 adl undriven top bit", {7'd0, adl_out[7]}, 8'h00);
    show();
    check("R8 adl valid", {7'd0, adl_out_vld}, 8'h01);

    // R9: SB split enables with hold = A5
    load_ops(8'hA5, 8'h00, 2'd0);
    run_op(3'd3, 1'b0);
    @(negedge clk); idle(); drv_sb_lo = 1; #1;
    check("R9 sb lo only", sb_out, 8'h25);
    check("R9 sb lo valid", {6'd0, sb_hi_vld, sb_lo_vld}, 8'h01);
    @(negedge clk); idle(); drv_sb_hi = 1; #1;
    check("R9 sb hi only", sb_out, 8'h80);
    check("R9 sb hi valid", {6'd0, sb_hi_vld, sb_lo_vld}, 8'h02);
    @(negedge clk); idle(); drv_sb_lo = 1; drv_sb_hi = 1; #1;
    check("R9 sb both", sb_out, 8'hA5);
    @(negedge clk); idle(); #1;
    check("R9 sb none", sb_out, 8'h00);

    // R10: load coinciding with op uses old operand
    load_ops(8'h11, 8'h22, 2'd0);
    @(negedge clk); idle(); op_sum = 1; sb_bus = 8'hF0; ld_a_sb = 1;
    show();
    check("R10 old operand used", adl_out, 8'h33);
    run_op(3'd0, 1'b0); show();
    check("R10 new operand next op", adl_out, 8'h12);
    check("R10 carry next op", {7'd0, carry_out}, 8'h01);

    // R1: reset mid-run clears hold asynchronously
    @(negedge clk); idle(); rst_n = 0; drv_adl = 1; #1;
    check("R1 async clear", adl_out, 8'h00);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    show();
    check("R1 flags after second reset", {6'd0, carry_out, ovf_out}, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule